// File: doc/BRIEF.md
# Synchronous Burst SRAM with Internal Burst Counter

This block is a single-port synchronous static memory of 256 words by 16 bits. Registers on the rising clock edge capture every input. A low level on the load strobe at a rising edge latches a starting address, the access direction and the burst-order selection. An internal address register then steps through a fixed four-beat burst, so the host gives one address per burst and not one per word.

The order input picks one of two sequences for the two low address bits. The linear sequence counts upward modulo four. The interleaved sequence XORs the start offset with the beat number. The upper address bits never change inside a burst.

Write data for each beat is captured one edge after that beat's address is presented. For the first beat, this is the edge after the load edge. The captured word is committed to the array on the following edge. Read data passes through an output register, so each word stays stable for one full clock period, and a drive-enable output marks the cycles in which the block owns the shared data bus. A new load strobe in the middle of a burst abandons the beats that remain and starts the new access.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rdata_oe_o` is 0 and `rdata_o` is 0.
- R2: A rising edge with `load_n_i` low latches `addr_i`, the direction (`write_n_i` low means write) and `order_i`. The next four edges with `load_n_i` high each perform one beat. During those beats, `addr_i`, `write_n_i` and `order_i` are ignored. After the fourth beat the block is idle.
- R3: With `order_i` = 0 latched (linear), beat k (k = 0..3) uses address bits [1:0] = (start[1:0] + k) mod 4, and bits [7:2] equal to the start address.
- R4: With `order_i` = 1 latched (interleaved), beat k uses address bits [1:0] = start[1:0] XOR k, and bits [7:2] equal to the start address.
- R5: In a write burst, the word on `wdata_i` at the (k+1)-th edge after the load edge is stored at the address of beat k, and a later read of that address returns it.
- R6: In a read burst, the word for beat k appears on `rdata_o` right after the (k+1)-th edge after the load edge and stays for one full cycle, with `rdata_oe_o` = 1. In every other cycle `rdata_oe_o` is 0, and this includes every cycle of a write burst.
- R7: `rdata_o` keeps its last read word in cycles that carry no read beat.
- R8: An edge with `load_n_i` low performs no beat, even during a burst. The beats left in the interrupted burst never happen, so unwritten locations keep their old contents, and the new burst starts from the new address.
- R9: The bus turnaround rule: a write may only be loaded on an edge at which `rdata_oe_o` is 0. This leaves one idle bus cycle between a read burst and the following write burst.
- R10: A change of `order_i` after the load edge has no effect on the order of the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Burst start address, sampled on a load edge |
| load_n_i | input | 1 | Active-low load strobe |
| write_n_i | input | 1 | Active-low write select, sampled on a load edge |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata_i | input | 16 | Write data, captured one edge after each beat address |
| rdata_o | output | 16 | Registered read data |
| rdata_oe_o | output | 1 | High while `rdata_o` carries a read beat (bus drive enable) |

## Verification
Write bursts fill four aligned groups from starts with every low-offset value. Half use linear order and half use interleaved order. Each group is then read back with the other order from a different start. A word that lands in the wrong slot therefore shows up as a miscompare, because the two orders visit the same four locations in different sequences. While every burst runs, the address, order and write-select inputs change on every cycle, which shows whether the latched control alone drives the burst. A read interrupted after its first beat and a write interrupted after its second beat are then read back to tell skipped beats apart from beats that were performed.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

    // Number of address bits walked by the burst counter (4-beat burst).
    localparam int unsigned BURST_BITS = 2;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    // Low address bits of a beat, given the start offset and beat index.
    function automatic logic [BURST_BITS-1:0] burst_offset(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat,
        input burst_order_e          order
    );
        if (order == ORDER_INTERLEAVED) begin
            return start ^ beat;
        end
        return start + beat;
    endfunction

endpackage

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              load_n_i,
    input  logic              write_n_i,
    input  logic              order_i,
    output logic              beat_go_o,
    output logic              beat_wr_o,
    output logic [ADDR_W-1:0] beat_addr_o
);

    localparam int unsigned BB = BURST_BITS;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BB-1:0]     start_lo;
        logic [BB-1:0]     beat;
        logic              active;
        logic              write;
        burst_order_e      order;
    } seq_state_t;

    seq_state_t seq_d, seq_q;
    logic [BB-1:0] beat_nxt;
    logic          beat_last;

    assign beat_nxt  = seq_q.beat + {{(BB-1){1'b0}}, 1'b1};
    assign beat_last = (seq_q.beat == {BB{1'b1}});

    always_comb begin
        seq_d = seq_q;
        if (!load_n_i) begin
            // Load edge: latch address and control, no beat this edge.
            seq_d.addr     = addr_i;
            seq_d.start_lo = addr_i[BB-1:0];
            seq_d.beat     = '0;
            seq_d.active   = 1'b1;
            seq_d.write    = ~write_n_i;
            seq_d.order    = burst_order_e'(order_i);
        end else if (seq_q.active) begin
            // Beat edge: address register steps to the next beat.
            seq_d.beat = beat_nxt;
            seq_d.addr = {seq_q.addr[ADDR_W-1:BB],
                          burst_offset(seq_q.start_lo, beat_nxt, seq_q.order)};
            if (beat_last) begin
                seq_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign beat_go_o   = seq_q.active & load_n_i;
    assign beat_wr_o   = seq_q.write;
    assign beat_addr_o = seq_q.addr;

    // R2: a load edge leaves the counter at beat 0 of an active burst.
    assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_i) |=> (seq_q.active && seq_q.beat == '0));

    // R2: the fourth beat closes the burst.
    assert_burst_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && load_n_i && beat_last) |=> !seq_q.active);

    // R3/R4: upper address bits stay put while the burst advances.
    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && load_n_i)
        |=> (seq_q.addr[ADDR_W-1:BB] == $past(seq_q.addr[ADDR_W-1:BB])));

    // R3: linear order steps the low bits by one each beat.
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && load_n_i && !beat_last && seq_q.order == ORDER_LINEAR)
        |=> (seq_q.addr[BB-1:0] == $past(seq_q.addr[BB-1:0]) + {{(BB-1){1'b0}}, 1'b1}));

    // R4: interleaved order flips exactly the bits that the beat count flips.
    assert_interleave_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && load_n_i && !beat_last && seq_q.order == ORDER_INTERLEAVED)
        |=> ((seq_q.addr[BB-1:0] ^ $past(seq_q.addr[BB-1:0])) == $past(seq_q.beat ^ beat_nxt)));

    // R10: the latched order does not move during a burst.
    assert_order_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && load_n_i) |=> (seq_q.order == $past(seq_q.order)));

endmodule

// File: rtl/burst_io_stage.sv
`timescale 1ns/1ps
module burst_io_stage #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_go_i,
    input  logic              beat_wr_i,
    input  logic [ADDR_W-1:0] beat_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] array_rdata_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              oe_o
);

    typedef struct packed {
        logic [DATA_W-1:0] in_data;
        logic [ADDR_W-1:0] waddr;
        logic              wpend;
        logic [DATA_W-1:0] dout;
        logic              oe;
    } io_state_t;

    io_state_t io_d, io_q;
    logic      rd_beat;
    logic      wr_beat;

    assign rd_beat = beat_go_i & ~beat_wr_i;
    assign wr_beat = beat_go_i &  beat_wr_i;

    always_comb begin
        io_d       = io_q;
        io_d.wpend = wr_beat;
        io_d.oe    = rd_beat;
        if (wr_beat) begin
            io_d.in_data = wdata_i;
            io_d.waddr   = beat_addr_i;
        end
        if (rd_beat) begin
            io_d.dout = array_rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_q <= '0;
        end else begin
            io_q <= io_d;
        end
    end

    assign wr_en_o   = io_q.wpend;
    assign wr_addr_o = io_q.waddr;
    assign wr_data_o = io_q.in_data;
    assign rdata_o   = io_q.dout;
    assign oe_o      = io_q.oe;

    // R6: the bus is driven only in the cycle after a read beat.
    assert_oe_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> $past(beat_go_i && !beat_wr_i));

    // R5: a pending commit always stems from a write beat one edge earlier.
    assert_commit_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(beat_go_i && beat_wr_i));

    // R7: without a read beat the output register keeps its word.
    assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_go_i && !beat_wr_i) |=> $stable(rdata_o));

endmodule

// File: rtl/burst_array.sv
`timescale 1ns/1ps
module burst_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              load_n_i,
    input  logic              write_n_i,
    input  logic              order_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o
);

    logic              beat_go;
    logic              beat_wr;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] array_rdata;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;

    burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .load_n_i    (load_n_i),
        .write_n_i   (write_n_i),
        .order_i     (order_i),
        .beat_go_o   (beat_go),
        .beat_wr_o   (beat_wr),
        .beat_addr_o (beat_addr)
    );

    burst_io_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk           (clk),
        .rst_n         (rst_n),
        .beat_go_i     (beat_go),
        .beat_wr_i     (beat_wr),
        .beat_addr_i   (beat_addr),
        .wdata_i       (wdata_i),
        .array_rdata_i (array_rdata),
        .wr_en_o       (commit_en),
        .wr_addr_o     (commit_addr),
        .wr_data_o     (commit_data),
        .rdata_o       (rdata_o),
        .oe_o          (rdata_oe_o)
    );

    burst_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .wr_en_i   (commit_en),
        .wr_addr_i (commit_addr),
        .wr_data_i (commit_data),
        .rd_addr_i (beat_addr),
        .rd_data_o (array_rdata)
    );

    // R8: a load edge never produces a read beat on the bus.
    assert_load_no_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_i) |=> !rdata_oe_o);

    // R9: a write may be loaded only while the bus is released.
    assert_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_i && !write_n_i) |-> !rdata_oe_o);

    // R1: reset state of the output stage.
    always_comb begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (rdata_oe_o == 1'b0 && rdata_o == '0);
        end
    end

endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_i = 8'h00;
    logic        load_n_i = 1'b1;
    logic        write_n_i = 1'b1;
    logic        order_i = 1'b0;
    logic [15:0] wdata_i = 16'h0000;
    logic [15:0] rdata_o;
    logic        rdata_oe_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] mem_m [256];

    always #5 clk = ~clk;

    burst_sram u_burst_sram (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .load_n_i   (load_n_i),
        .write_n_i  (write_n_i),
        .order_i    (order_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .rdata_oe_o (rdata_oe_o)
    );

    function automatic logic [7:0] beat_addr(input logic [7:0] st, input int k, input logic md);
        logic [1:0] kk;
        kk = k[1:0];
        if (md) return {st[7:2], st[1:0] ^ kk};
        return {st[7:2], st[1:0] + kk};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 oe in reset", {15'd0, rdata_oe_o}, 16'd0);
        check("R1 rdata in reset", rdata_o, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after release", {15'd0, rdata_oe_o}, 16'd0);
        check("R1 rdata after release", rdata_o, 16'd0);
    endtask

    // R5: write burst of nbeats beats (4 = full burst, fewer = cut short by the next load).
    task automatic t_write(input logic [7:0] st, input logic md, input logic [15:0] seed, input int nbeats);
        load_n_i = 1'b0; write_n_i = 1'b0; addr_i = st; order_i = md;
        for (int k = 0; k < nbeats; k++) begin
            @(negedge clk);
            check("R6 oe low during write", {15'd0, rdata_oe_o}, 16'd0);
            load_n_i = 1'b1;
            write_n_i = ~write_n_i;      // R2: ignored mid-burst
            addr_i = addr_i + 8'h5B;     // R2: ignored mid-burst
            order_i = ~order_i;          // R10: ignored mid-burst
            wdata_i = seed + 16'(k * 16'h1111);
            mem_m[beat_addr(st, k, md)] = wdata_i;
        end
        @(negedge clk);
        write_n_i = 1'b1;
    endtask

    // R2/R3/R4/R6/R7/R10: read burst; returns after the idle cycle.
    task automatic t_read(input logic [7:0] st, input logic md, input int nbeats);
        logic [15:0] last;
        last = 16'h0;
        load_n_i = 1'b0; write_n_i = 1'b1; addr_i = st; order_i = md;
        @(negedge clk);
        check("R8 no beat on load edge", {15'd0, rdata_oe_o}, 16'd0);
        load_n_i = 1'b1;
        write_n_i = 1'b0;                // R2: direction ignored mid-burst
        addr_i = ~st;
        order_i = ~md;                   // R10
        for (int k = 0; k < nbeats; k++) begin
            @(negedge clk);
            check("R6 oe during read beat", {15'd0, rdata_oe_o}, 16'd1);
            last = mem_m[beat_addr(st, k, md)];
            check(md ? "R4 R10 interleaved read data" : "R3 R10 linear read data", rdata_o, last);
            addr_i = addr_i + 8'h35;
            order_i = ~order_i;
        end
        if (nbeats == 4) begin
            write_n_i = 1'b1;
            @(negedge clk);
            check("R9 R6 bus released after read", {15'd0, rdata_oe_o}, 16'd0);
            check("R7 rdata held", rdata_o, last);
            @(negedge clk);
            check("R2 no fifth beat", {15'd0, rdata_oe_o}, 16'd0);
            check("R7 rdata still held", rdata_o, last);
        end else begin
            write_n_i = 1'b1;
        end
    endtask

    // R8: write cut after two beats, then a read overlapping the skipped slots.
    task automatic t_abort_write();
        logic [15:0] old2, old3;
        old2 = mem_m[8'h12];
        old3 = mem_m[8'h13];
        t_write(8'h10, 1'b0, 16'hA0A0, 2);
        check("R8 model untouched slot 12", mem_m[8'h12], old2);
        t_read(8'h12, 1'b0, 4);          // 12,13 old; 10,11 new
        check("R8 model untouched slot 13", mem_m[8'h13], old3);
    endtask

    // R8: read cut after the first beat by a new read load.
    task automatic t_abort_read();
        t_read(8'h44, 1'b0, 1);
        t_read(8'h80, 1'b1, 4);
    endtask

    initial begin
        t_reset();
        // Fill four aligned groups, every start offset, both orders.
        t_write(8'h47, 1'b0, 16'h1000, 4);
        t_write(8'h82, 1'b1, 16'h2000, 4);
        t_write(8'h11, 1'b1, 16'h3000, 4);
        t_write(8'hF0, 1'b0, 16'h4000, 4);
        // Read each group back with the other order.
        t_read(8'h45, 1'b1, 4);
        t_read(8'h83, 1'b0, 4);
        t_read(8'h13, 1'b0, 4);
        t_read(8'hF3, 1'b1, 4);
        // Write right after a read, following the idle cycle (R9).
        t_write(8'hF2, 1'b1, 16'h5000, 4);
        t_read(8'hF1, 1'b0, 4);
        t_abort_write();
        t_abort_read();
        t_read(8'h46, 1'b1, 4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule